// File: doc/BRIEF.md
# DDR SDRAM Burst Command Sequencer

This block sits on the controller side of a double-data-rate SDRAM. It takes one request at a time from a user port. Each request carries a bank, a row, a starting column, a read/write flag and a full burst of write data. The engine drives the chip-select, row-strobe, column-strobe and write-enable command pins and the address and bank pins. For every request it issues an ACTIVATE, waits out the configured activate-to-column delay, and then issues the READ or WRITE column command.

The double-rate data and strobe pins are modelled as two lanes per clock, so the design stays synthesizable. The rising lane is the first half of a clock and the falling lane is the second half. On writes the engine frames the data with a strobe preamble and a postamble. On reads it counts the CAS latency in half-clock slots. It captures each beat from the correct lane and returns the beat together with the column it belongs to. Burst length, burst ordering, CAS latency and the activate-to-column delay are configuration inputs, sampled when a request is accepted.

Top module: `ddr_burst_seq`

## Requirements
- R1: A request is taken in a cycle where `reqReady` and `reqValid` are both high. In the next cycle the pins show ACTIVATE (CS#=0, RAS#=0, CAS#=1, WE#=1) with the row on `memAddr` and the bank on `memBank`. `reqReady` stays low from then until the burst has completed.
- R2: Every cycle that carries no command shows NOP on the pins (CS#=0, RAS#=1, CAS#=1, WE#=1).
- R3: A read column command is CS#=0, RAS#=1, CAS#=0, WE#=1. A write column command is the same except WE#=0. Both carry the starting column on `memAddr` and the request's bank on `memBank`.
- R4: The column command shows on the pins exactly max(`cfgTrcd`,1) clocks after the ACTIVATE.
- R5: `cfgBurstLen` code 0 selects 2 beats, code 1 selects 4 beats, and codes 2 and 3 select 8 beats. All configuration inputs are sampled at acceptance.
- R6: Beat b of a burst addresses column (start & ~(BL-1)) | off(b). Here s = start & (BL-1). When `cfgInterleave`=1, off(b) = s XOR b. When `cfgInterleave`=0, off(b) = (s+b) mod BL. Write beat b takes word off(b) of `reqWrData` (word w in bits [16w+15:16w]). Each returned read beat carries its column.
- R7: The cycle after a write command is a preamble: `dqsOe`=2'b11, both strobe lanes 0, `dqOe`=0. The next BL/2 cycles carry the data: `dqOe`=1, beat 2k on the rising lane and beat 2k+1 on the falling lane, strobe rising lane 1 and falling lane 0.
- R8: The cycle after the last write data cycle is a postamble: `dqsOe`=2'b01 and the strobe driven 0. After that cycle, and whenever no write is in progress, `dqsOe`=2'b00 and `dqOe`=0.
- R9: Words of `reqWrData` that lie outside the burst (offset at or above BL) never reach the data lanes.
- R10: `cfgCasLat` code 0 selects CL2, code 1 selects CL2.5, and codes 2 and 3 select CL3. Count half-clock slots from the column command's clock edge: even slot 2j is the rising lane of clock j and odd slot 2j+1 is its falling lane. Read beat b is sampled from slot 2·CL+b. The beat is presented one clock after its sample clock on the matching `rd*` lane, with its valid bit set.
- R11: Values on `dqInRise`/`dqInFall` outside the burst's slots are never presented as read beats.
- R12: During and after reset, the pins show NOP, all output enables and read valids are 0, and `reqReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Engine idle, request can be taken |
| reqWrite | input | 1 | 1 = write burst, 0 = read burst |
| reqBank | input | BA_W | Bank of the request |
| reqRow | input | ROW_W | Row to activate |
| reqCol | input | COL_W | Starting column |
| reqWrData | input | 8*DQ_W | Write words indexed by column offset in the burst block |
| cfgTrcd | input | TRCD_W | Activate-to-column delay in clocks |
| cfgCasLat | input | 2 | CAS latency code |
| cfgBurstLen | input | 2 | Burst length code |
| cfgInterleave | input | 1 | 1 = interleaved order, 0 = sequential |
| memCsN | output | 1 | Chip select, active low |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write enable, active low |
| memAddr | output | ADDR_W | Row or column address |
| memBank | output | BA_W | Bank address |
| dqOutRise | output | DQ_W | Write data, first half-clock |
| dqOutFall | output | DQ_W | Write data, second half-clock |
| dqOe | output | 1 | Data lanes driven |
| dqsOutRise | output | 1 | Strobe level, first half-clock |
| dqsOutFall | output | 1 | Strobe level, second half-clock |
| dqsOe | output | 2 | Strobe drive enable per half ([0] first, [1] second) |
| dqInRise | input | DQ_W | Read data seen in first half-clock |
| dqInFall | input | DQ_W | Read data seen in second half-clock |
| rdRiseValid | output | 1 | Read beat present on the rising-lane outputs |
| rdRiseData | output | DQ_W | Read beat from the rising lane |
| rdRiseCol | output | COL_W | Column of that beat |
| rdFallValid | output | 1 | Read beat present on the falling-lane outputs |
| rdFallData | output | DQ_W | Read beat from the falling lane |
| rdFallCol | output | COL_W | Column of that beat |

## Verification
The bench targets the half-clock latency, starting columns in the middle of a block under both orderings, every burst length, and the edges of the write window.

- An error in the CL2.5 lane selection would capture the unrelated values the memory model drives outside the burst, so the returned data would mismatch.
- A wrapped-address error would tag beats with the wrong columns.
- A write engine that read the wrong word would place the out-of-block filler words on the data lanes.
- An off-by-one in the preamble or postamble would shift the strobe enables or make `reqReady` rise too early.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

  localparam int BEAT_W    = 3;
  localparam int BEATS_MAX = 1 << BEAT_W;

  typedef enum logic [1:0] {CMD_NOP, CMD_ACT, CMD_COL} cmdSel_e;
  typedef enum logic [1:0] {WP_IDLE, WP_PRE, WP_DATA, WP_POST} wrPhase_e;

  // strobes from control to datapath, evaluated in the cycle before the edge
  typedef struct packed {
    cmdSel_e                cmd;
    logic                   loadReq;
    wrPhase_e               wrPhase;
    logic [BEAT_W-2:0]      wrPair;
    logic                   capRise;
    logic                   capFall;
    logic [BEAT_W-1:0]      riseBeat;
    logic [BEAT_W-1:0]      fallBeat;
  } seqStrobe_t;

  function automatic logic [BEAT_W:0] burstBeats(input logic [1:0] code);
    case (code)
      2'd0:    return (BEAT_W+1)'(2);
      2'd1:    return (BEAT_W+1)'(4);
      default: return (BEAT_W+1)'(8);
    endcase
  endfunction

  // CAS latency expressed in half clocks
  function automatic logic [2:0] casHalves(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd4;
      2'd1:    return 3'd5;
      default: return 3'd6;
    endcase
  endfunction

  function automatic logic [BEAT_W-1:0] beatOffset(input logic [BEAT_W-1:0] startOff,
                                                   input logic [BEAT_W-1:0] beat,
                                                   input logic [BEAT_W:0]   beats,
                                                   input logic              interleave);
    logic [BEAT_W-1:0] mask;
    mask = beats[BEAT_W-1:0] - 1'b1;
    if (interleave) return (startOff ^ beat) & mask;
    return (startOff + beat) & mask;
  endfunction

endpackage

// File: rtl/ddr_seq_ctrl.sv
module ddr_seq_ctrl
  import ddr_seq_pkg::*;
#(
  parameter int TRCD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [TRCD_W-1:0] cfgTrcd,
  input  logic [1:0]        cfgCasLat,
  input  logic [1:0]        cfgBurstLen,
  output seqStrobe_t        strobe
);

  localparam int PH_W = BEAT_W + 2;
  localparam int SI_W = PH_W + 2;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_WR, S_RD} state_e;

  state_e              state, nextState;
  logic [TRCD_W-1:0]   waitCnt;
  logic [PH_W-1:0]     phaseCnt;
  logic                isWrite;
  logic [BEAT_W:0]     beats;
  logic [2:0]          casH;

  logic signed [SI_W-1:0] riseIdx, fallIdx, beatsS, lastIdx;
  logic [PH_W-1:0]        halfBeats;
  logic [PH_W-1:0]        pairIdx;

  always_comb begin
    riseIdx   = $signed({1'b0, phaseCnt, 1'b0}) - $signed(SI_W'(2))
              - $signed({{(SI_W-3){1'b0}}, casH});
    fallIdx   = riseIdx + $signed(SI_W'(1));
    beatsS    = $signed({{(SI_W-BEAT_W-1){1'b0}}, beats});
    lastIdx   = beatsS - $signed(SI_W'(1));
    halfBeats = {{(PH_W-BEAT_W){1'b0}}, beats[BEAT_W:1]};
    pairIdx   = phaseCnt - 1'b1;

    strobe         = '0;
    strobe.cmd     = CMD_NOP;
    strobe.wrPhase = WP_IDLE;
    nextState      = state;
    reqReady       = 1'b0;

    case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.cmd     = CMD_ACT;
          strobe.loadReq = 1'b1;
          nextState      = S_WAIT;
        end
      end
      S_WAIT: begin
        if (waitCnt == '0) begin
          strobe.cmd = CMD_COL;
          nextState  = isWrite ? S_WR : S_RD;
        end
      end
      S_WR: begin
        if (phaseCnt == '0) begin
          strobe.wrPhase = WP_PRE;
        end else if (phaseCnt <= halfBeats) begin
          strobe.wrPhase = WP_DATA;
          strobe.wrPair  = pairIdx[BEAT_W-2:0];
        end else begin
          strobe.wrPhase = WP_POST;
          nextState      = S_IDLE;
        end
      end
      default: begin
        strobe.capRise  = (riseIdx >= 0) && (riseIdx < beatsS);
        strobe.capFall  = (fallIdx >= 0) && (fallIdx < beatsS);
        strobe.riseBeat = riseIdx[BEAT_W-1:0];
        strobe.fallBeat = fallIdx[BEAT_W-1:0];
        if ((strobe.capRise && riseIdx == lastIdx) ||
            (strobe.capFall && fallIdx == lastIdx))
          nextState = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      waitCnt  <= '0;
      phaseCnt <= '0;
      isWrite  <= 1'b0;
      beats    <= (BEAT_W+1)'(2);
      casH     <= 3'd4;
    end else begin
      state <= nextState;
      if (strobe.loadReq) begin
        isWrite <= reqWrite;
        beats   <= burstBeats(cfgBurstLen);
        casH    <= casHalves(cfgCasLat);
        waitCnt <= (cfgTrcd == '0) ? '0 : cfgTrcd - 1'b1;
      end else if (state == S_WAIT && waitCnt != '0) begin
        waitCnt <= waitCnt - 1'b1;
      end
      if (strobe.cmd == CMD_COL)
        phaseCnt <= '0;
      else if (state == S_WR || state == S_RD)
        phaseCnt <= phaseCnt + 1'b1;
    end
  end

endmodule

// File: rtl/ddr_seq_dpath.sv
module ddr_seq_dpath
  import ddr_seq_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int ADDR_W = 12,
  parameter int DQ_W   = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqStrobe_t                strobe,
  input  logic                      reqWrite,
  input  logic [BA_W-1:0]           reqBank,
  input  logic [ROW_W-1:0]          reqRow,
  input  logic [COL_W-1:0]          reqCol,
  input  logic [BEATS_MAX*DQ_W-1:0] reqWrData,
  input  logic [1:0]                cfgBurstLen,
  input  logic                      cfgInterleave,
  input  logic [DQ_W-1:0]           dqInRise,
  input  logic [DQ_W-1:0]           dqInFall,
  output logic                      memCsN,
  output logic                      memRasN,
  output logic                      memCasN,
  output logic                      memWeN,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [BA_W-1:0]           memBank,
  output logic [DQ_W-1:0]           dqOutRise,
  output logic [DQ_W-1:0]           dqOutFall,
  output logic                      dqOe,
  output logic                      dqsOutRise,
  output logic                      dqsOutFall,
  output logic [1:0]                dqsOe,
  output logic                      rdRiseValid,
  output logic [DQ_W-1:0]           rdRiseData,
  output logic [COL_W-1:0]          rdRiseCol,
  output logic                      rdFallValid,
  output logic [DQ_W-1:0]           rdFallData,
  output logic [COL_W-1:0]          rdFallCol
);

  logic [BA_W-1:0]           bankQ;
  logic [COL_W-1:0]          colQ;
  logic [BEATS_MAX*DQ_W-1:0] dataQ;
  logic                      writeQ;
  logic [BEAT_W:0]           beatsQ;
  logic                      interQ;

  logic [BEAT_W-1:0] wrRiseOff, wrFallOff, rdRiseOff, rdFallOff;
  logic [COL_W-1:0]  blockBase;

  always_comb begin
    blockBase = colQ & ~{{(COL_W-BEAT_W){1'b0}}, beatsQ[BEAT_W-1:0] - 1'b1};
    wrRiseOff = beatOffset(colQ[BEAT_W-1:0], {strobe.wrPair, 1'b0}, beatsQ, interQ);
    wrFallOff = beatOffset(colQ[BEAT_W-1:0], {strobe.wrPair, 1'b1}, beatsQ, interQ);
    rdRiseOff = beatOffset(colQ[BEAT_W-1:0], strobe.riseBeat, beatsQ, interQ);
    rdFallOff = beatOffset(colQ[BEAT_W-1:0], strobe.fallBeat, beatsQ, interQ);
  end

  // request capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ  <= '0;
      colQ   <= '0;
      dataQ  <= '0;
      writeQ <= 1'b0;
      beatsQ <= (BEAT_W+1)'(2);
      interQ <= 1'b0;
    end else if (strobe.loadReq) begin
      bankQ  <= reqBank;
      colQ   <= reqCol;
      dataQ  <= reqWrData;
      writeQ <= reqWrite;
      beatsQ <= burstBeats(cfgBurstLen);
      interQ <= cfgInterleave;
    end
  end

  // command and address pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {memCsN, memRasN, memCasN, memWeN} <= 4'b0111;
      memAddr <= '0;
      memBank <= '0;
    end else begin
      memAddr <= '0;
      memBank <= '0;
      case (strobe.cmd)
        CMD_ACT: begin
          {memCsN, memRasN, memCasN, memWeN} <= 4'b0011;
          memAddr[ROW_W-1:0] <= reqRow;
          memBank            <= reqBank;
        end
        CMD_COL: begin
          {memCsN, memRasN, memCasN, memWeN} <= {3'b010, ~writeQ};
          memAddr[COL_W-1:0] <= colQ;
          memBank            <= bankQ;
        end
        default: {memCsN, memRasN, memCasN, memWeN} <= 4'b0111;
      endcase
    end
  end

  // write lanes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dqOutRise  <= '0;
      dqOutFall  <= '0;
      dqOe       <= 1'b0;
      dqsOutRise <= 1'b0;
      dqsOutFall <= 1'b0;
      dqsOe      <= 2'b00;
    end else begin
      dqOe       <= 1'b0;
      dqsOutRise <= 1'b0;
      dqsOutFall <= 1'b0;
      case (strobe.wrPhase)
        WP_PRE:  dqsOe <= 2'b11;
        WP_DATA: begin
          dqsOe      <= 2'b11;
          dqsOutRise <= 1'b1;
          dqOe       <= 1'b1;
          dqOutRise  <= dataQ[int'(wrRiseOff)*DQ_W +: DQ_W];
          dqOutFall  <= dataQ[int'(wrFallOff)*DQ_W +: DQ_W];
        end
        WP_POST: dqsOe <= 2'b01;
        default: dqsOe <= 2'b00;
      endcase
    end
  end

  // read capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdRiseValid <= 1'b0;
      rdFallValid <= 1'b0;
      rdRiseData  <= '0;
      rdFallData  <= '0;
      rdRiseCol   <= '0;
      rdFallCol   <= '0;
    end else begin
      rdRiseValid <= strobe.capRise;
      rdFallValid <= strobe.capFall;
      if (strobe.capRise) begin
        rdRiseData <= dqInRise;
        rdRiseCol  <= blockBase | {{(COL_W-BEAT_W){1'b0}}, rdRiseOff};
      end
      if (strobe.capFall) begin
        rdFallData <= dqInFall;
        rdFallCol  <= blockBase | {{(COL_W-BEAT_W){1'b0}}, rdFallOff};
      end
    end
  end

endmodule

// File: rtl/ddr_burst_seq.sv
module ddr_burst_seq
  import ddr_seq_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int ADDR_W = 12,
  parameter int DQ_W   = 16,
  parameter int TRCD_W = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  output logic                      reqReady,
  input  logic                      reqWrite,
  input  logic [BA_W-1:0]           reqBank,
  input  logic [ROW_W-1:0]          reqRow,
  input  logic [COL_W-1:0]          reqCol,
  input  logic [BEATS_MAX*DQ_W-1:0] reqWrData,
  input  logic [TRCD_W-1:0]         cfgTrcd,
  input  logic [1:0]                cfgCasLat,
  input  logic [1:0]                cfgBurstLen,
  input  logic                      cfgInterleave,
  output logic                      memCsN,
  output logic                      memRasN,
  output logic                      memCasN,
  output logic                      memWeN,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [BA_W-1:0]           memBank,
  output logic [DQ_W-1:0]           dqOutRise,
  output logic [DQ_W-1:0]           dqOutFall,
  output logic                      dqOe,
  output logic                      dqsOutRise,
  output logic                      dqsOutFall,
  output logic [1:0]                dqsOe,
  input  logic [DQ_W-1:0]           dqInRise,
  input  logic [DQ_W-1:0]           dqInFall,
  output logic                      rdRiseValid,
  output logic [DQ_W-1:0]           rdRiseData,
  output logic [COL_W-1:0]          rdRiseCol,
  output logic                      rdFallValid,
  output logic [DQ_W-1:0]           rdFallData,
  output logic [COL_W-1:0]          rdFallCol
);

  seqStrobe_t strobe;

  ddr_seq_ctrl #(.TRCD_W(TRCD_W)) ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .reqWrite    (reqWrite),
    .cfgTrcd     (cfgTrcd),
    .cfgCasLat   (cfgCasLat),
    .cfgBurstLen (cfgBurstLen),
    .strobe      (strobe)
  );

  ddr_seq_dpath #(
    .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .DQ_W(DQ_W)
  ) dpath (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .reqWrite      (reqWrite),
    .reqBank       (reqBank),
    .reqRow        (reqRow),
    .reqCol        (reqCol),
    .reqWrData     (reqWrData),
    .cfgBurstLen   (cfgBurstLen),
    .cfgInterleave (cfgInterleave),
    .dqInRise      (dqInRise),
    .dqInFall      (dqInFall),
    .memCsN        (memCsN),
    .memRasN       (memRasN),
    .memCasN       (memCasN),
    .memWeN        (memWeN),
    .memAddr       (memAddr),
    .memBank       (memBank),
    .dqOutRise     (dqOutRise),
    .dqOutFall     (dqOutFall),
    .dqOe          (dqOe),
    .dqsOutRise    (dqsOutRise),
    .dqsOutFall    (dqsOutFall),
    .dqsOe         (dqsOe),
    .rdRiseValid   (rdRiseValid),
    .rdRiseData    (rdRiseData),
    .rdRiseCol     (rdRiseCol),
    .rdFallValid   (rdFallValid),
    .rdFallData    (rdFallData),
    .rdFallCol     (rdFallCol)
  );

endmodule

// File: rtl/ddr_burst_seq_chk.sv
module ddr_burst_seq_chk #(
  parameter int TRCD_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [TRCD_W-1:0] cfgTrcd,
  input logic              memCsN,
  input logic              memRasN,
  input logic              memCasN,
  input logic              memWeN,
  input logic              dqOe,
  input logic              dqsOutRise,
  input logic              dqsOutFall,
  input logic [1:0]        dqsOe,
  input logic              rdRiseValid,
  input logic              rdFallValid
);

  logic              isAct, isCol, isWr;
  logic [TRCD_W-1:0] trcdQ;
  logic [TRCD_W:0]   sinceAct;
  logic [TRCD_W:0]   effTrcd;

  assign isAct   = !memCsN && !memRasN && memCasN && memWeN;
  assign isCol   = !memCsN && memRasN && !memCasN;
  assign isWr    = isCol && !memWeN;
  assign effTrcd = (trcdQ == '0) ? (TRCD_W+1)'(1) : {1'b0, trcdQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trcdQ    <= '0;
      sinceAct <= '0;
    end else begin
      if (reqValid && reqReady) trcdQ <= cfgTrcd;
      if (isAct) sinceAct <= (TRCD_W+1)'(1);
      else if (sinceAct != '1 && sinceAct != '0) sinceAct <= sinceAct + 1'b1;
    end
  end

  // R1
  accept_gives_act_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> isAct && !reqReady);

  // R4
  trcd_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    isCol |-> sinceAct == effTrcd);

  // R7
  write_preamble_chk: assert property (@(posedge clk) disable iff (!rstN)
    isWr |=> dqsOe == 2'b11 && !dqOe && !dqsOutRise && !dqsOutFall);

  // R7
  strobe_in_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> dqsOe == 2'b11 && dqsOutRise && !dqsOutFall);

  // R8
  write_postamble_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dqOe) |-> dqsOe == 2'b01 && !dqsOutRise);

  // R8
  idle_lanes_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !dqOe && dqsOe != 2'b11);

  // R11
  no_read_while_writing_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> !rdRiseValid && !rdFallValid);

endmodule

bind ddr_burst_seq ddr_burst_seq_chk #(.TRCD_W(TRCD_W)) chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .cfgTrcd     (cfgTrcd),
  .memCsN      (memCsN),
  .memRasN     (memRasN),
  .memCasN     (memCasN),
  .memWeN      (memWeN),
  .dqOe        (dqOe),
  .dqsOutRise  (dqsOutRise),
  .dqsOutFall  (dqsOutFall),
  .dqsOe       (dqsOe),
  .rdRiseValid (rdRiseValid),
  .rdFallValid (rdFallValid)
);

// File: tb/tb_ddr_burst_seq.sv
`timescale 1ns/1ps
module tb_ddr_burst_seq;

  localparam int BA_W = 2, ROW_W = 12, COL_W = 8, ADDR_W = 12, DQ_W = 16, TRCD_W = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic              reqWrite = 1'b0;
  logic [BA_W-1:0]   reqBank = '0;
  logic [ROW_W-1:0]  reqRow = '0;
  logic [COL_W-1:0]  reqCol = '0;
  logic [8*DQ_W-1:0] reqWrData = '0;
  logic [TRCD_W-1:0] cfgTrcd = 4'd2;
  logic [1:0]        cfgCasLat = 2'd2;
  logic [1:0]        cfgBurstLen = 2'd1;
  logic              cfgInterleave = 1'b0;
  logic memCsN, memRasN, memCasN, memWeN;
  logic [ADDR_W-1:0] memAddr;
  logic [BA_W-1:0]   memBank;
  logic [DQ_W-1:0]   dqOutRise, dqOutFall;
  logic              dqOe, dqsOutRise, dqsOutFall;
  logic [1:0]        dqsOe;
  logic [DQ_W-1:0]   dqInRise = 16'hBEEF, dqInFall = 16'hBEEF;
  logic              rdRiseValid, rdFallValid;
  logic [DQ_W-1:0]   rdRiseData, rdFallData;
  logic [COL_W-1:0]  rdRiseCol, rdFallCol;

  ddr_burst_seq dut (.*);

  always #2 clk = ~clk;

  typedef struct { int kind; int a; int b; } item_t;
  localparam int K_ACT = 0, K_RD = 1, K_WR = 2, K_WBEAT = 3, K_RBEAT = 4, K_POST = 5;
  item_t expQ[$];

  int checks = 0, errors = 0;
  int cycNum = 0;
  bit running = 0;
  int actCyc = -1000, wrCmdCyc = -1000, rdCmdEdge = -1000;
  int curBl = 2, curClh = 6, curTrcd = 1, curCol = 0, curBank = 0;
  bit curInter = 0;

  always @(posedge clk) cycNum <= cycNum + 1;

  function automatic int beatCol(int b);
    int off;
    off = curCol & (curBl - 1);
    off = curInter ? ((off ^ b) & (curBl - 1)) : ((off + b) % curBl);
    return (curCol & ~(curBl - 1)) | off;
  endfunction

  function automatic logic [15:0] memPat(int bank, int col);
    return {6'h2A, 2'(bank), 8'(col)};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expectItem(int kind, int a, int b, string tag);
    item_t it;
    checks++;
    if (expQ.size() == 0) begin
      errors++;
      $display("FAIL %s: actual kind %0d %0h/%0h expected no item", tag, kind, a, b);
    end else begin
      it = expQ.pop_front();
      if (it.kind != kind || it.a != a || it.b != b) begin
        errors++;
        $display("FAIL %s: actual kind %0d %0h/%0h expected kind %0d %0h/%0h",
                 tag, kind, a, b, it.kind, it.a, it.b);
      end
    end
  endtask

  // monitor and memory model
  always @(negedge clk) begin
    if (rstN && running) begin
      bit act, col, nop;
      int r, j, rb, fb, half;
      logic [1:0] expOe;
      bit expDq;
      act = !memCsN && !memRasN && memCasN && memWeN;
      col = !memCsN && memRasN && !memCasN;
      nop = !memCsN && memRasN && memCasN && memWeN;
      if (act) begin
        expectItem(K_ACT, memBank, memAddr, "R1 activate");
        actCyc = cycNum;
      end else if (col) begin
        expectItem(memWeN ? K_RD : K_WR, memBank, memAddr, "R3 column command");
        check(cycNum - actCyc == curTrcd, "R4 act-to-column gap", cycNum - actCyc, curTrcd);
        if (!memWeN) wrCmdCyc = cycNum;
        else rdCmdEdge = cycNum + 1;
      end else begin
        check(nop, "R2 idle command", {memCsN, memRasN, memCasN, memWeN}, 4'b0111);
      end
      // write framing (R7, R8)
      half = curBl / 2;
      r = cycNum - wrCmdCyc;
      expDq = (r >= 2 && r <= 1 + half);
      expOe = (r >= 1 && r <= 1 + half) ? 2'b11 : (r == 2 + half) ? 2'b01 : 2'b00;
      check(dqsOe == expOe && dqOe == expDq && dqsOutRise == expDq && !dqsOutFall,
            "R7 R8 strobe framing", {dqsOe, dqOe, dqsOutRise, dqsOutFall},
            {expOe, expDq, expDq, 1'b0});
      if (dqOe) begin
        expectItem(K_WBEAT, dqOutRise, 0, "R6 R9 write beat rise");
        expectItem(K_WBEAT, dqOutFall, 0, "R6 R9 write beat fall");
      end
      if (dqsOe == 2'b01) expectItem(K_POST, 0, 0, "R8 postamble");
      if (rdRiseValid) expectItem(K_RBEAT, rdRiseCol, rdRiseData, "R10 R11 read beat rise");
      if (rdFallValid) expectItem(K_RBEAT, rdFallCol, rdFallData, "R10 R11 read beat fall");
      check(reqReady == (expQ.size() == 0), "R1 ready only when idle", reqReady, expQ.size() == 0);
      // memory drives burst slots, filler elsewhere
      j  = cycNum - rdCmdEdge;
      rb = 2 * j - curClh;
      fb = rb + 1;
      dqInRise <= (rb >= 0 && rb < curBl) ? memPat(curBank, beatCol(rb)) : 16'hDEAD;
      dqInFall <= (fb >= 0 && fb < curBl) ? memPat(curBank, beatCol(fb)) : 16'hDEAD;
    end
  end

  task automatic doReq(bit wr, int bank, int row, int col, int blc, int clc,
                       bit inter, int trcd, int seed);
    logic [8*DQ_W-1:0] data;
    item_t it;
    for (int w = 0; w < 8; w++) data[w*DQ_W +: DQ_W] = 16'(seed + w);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqBank = 2'(bank); reqRow = 12'(row);
    reqCol = 8'(col); reqWrData = data; cfgBurstLen = 2'(blc); cfgCasLat = 2'(clc);
    cfgInterleave = inter; cfgTrcd = 4'(trcd);
    curBl = (blc == 0) ? 2 : (blc == 1) ? 4 : 8;
    curClh = (clc == 0) ? 4 : (clc == 1) ? 5 : 6;
    curTrcd = (trcd == 0) ? 1 : trcd;
    curCol = col; curBank = bank; curInter = inter;
    @(posedge clk); #1;
    reqValid = 1'b0;
    it = '{K_ACT, bank, row}; expQ.push_back(it);
    it = '{wr ? K_WR : K_RD, bank, col}; expQ.push_back(it);
    for (int b = 0; b < curBl; b++) begin
      if (wr) it = '{K_WBEAT, int'(data[(beatCol(b) & (curBl - 1))*DQ_W +: DQ_W]), 0};
      else    it = '{K_RBEAT, beatCol(b), int'(memPat(bank, beatCol(b)))};
      expQ.push_back(it);
    end
    if (wr) begin it = '{K_POST, 0, 0}; expQ.push_back(it); end
    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(reqReady == 1'b1, "R12 ready in reset", reqReady, 1);
    check({memCsN, memRasN, memCasN, memWeN} == 4'b0111, "R12 NOP in reset",
          {memCsN, memRasN, memCasN, memWeN}, 4'b0111);
    check(dqsOe == 2'b00 && !dqOe, "R12 lanes off in reset", {dqsOe, dqOe}, 0);
    check(!rdRiseValid && !rdFallValid, "R12 no read beats in reset",
          {rdRiseValid, rdFallValid}, 0);
    rstN = 1'b1;
    running = 1'b1;
    // write BL4 sequential, mid-block start, filler words 4..7 (R5 R6 R9)
    doReq(1, 1, 12'h155, 8'h06, 1, 2, 0, 2, 16'h3100);
    // read BL8 interleaved CL3 (R6 R10 R11)
    doReq(0, 2, 12'h0A0, 8'h15, 2, 2, 1, 3, 0);
    // read BL4 sequential CL2
    doReq(0, 3, 12'h7FF, 8'h23, 1, 0, 0, 2, 0);
    // read BL2 CL2.5, burst code 0
    doReq(0, 0, 12'h001, 8'h41, 0, 1, 0, 2, 0);
    // write BL8 interleaved, tRCD 3
    doReq(1, 2, 12'h3C3, 8'h3B, 3, 2, 1, 3, 16'h5200);
    // read BL8 sequential CL2.5, tRCD 0 treated as 1 (R4), CL code 3 is CL3 tested below
    doReq(0, 1, 12'h222, 8'h7E, 2, 1, 0, 0, 0);
    // write BL2 tRCD 4, high filler words never used
    doReq(1, 3, 12'h444, 8'h11, 0, 0, 0, 4, 16'h7700);
    // read BL4 interleaved CL code 3 (CL3)
    doReq(0, 0, 12'h0F0, 8'hC6, 1, 3, 1, 1, 0);
    check(expQ.size() == 0, "R1 all items seen", expQ.size(), 0);
    running = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule